// File: doc/BRIEF.md
# Dual-Player Chess Clock Engine

This block keeps the remaining time of two players in tenths of a second. While the clock runs and no pause is held, it counts down the active player's time by one on each tick strobe. The system supplies that strobe every 100 ms. Move buttons reach this block already debounced. When the active player presses their button, the turn passes to the opponent. In the same cycle, the block applies whatever compensation the selected rule grants.

A stopped clock accepts a load command. The load takes a 3-bit preset that fixes the starting time and the bonus or delay, and a 2-bit rule code. The rule codes are 0 = sudden death, 1 = per-move increment, 2 = per-move delay (with a cap on the refund) and 3 = hourglass transfer. The load writes both counters, the rule, the bonus and the delay snapshot in one edge. A start pulse toggles between running and stopped. When a player's counter runs out, that player's flag latches and the clock halts. The flag stays set until the next load.

Top module: `chess_clock`

## Requirements
- R1: After reset both times are 0, player A (active_o = 0) holds the turn, running_o is 0 and both flags are 0.
- R2: A load_i pulse while stopped sets both times to the preset start, stores the rule and bonus, clears both flags and gives the turn to A. The presets are 0 = 54000 (bonus 300), 1 = 15000 (bonus 50), 2 = 1800 (bonus 20), 3 = 600 (bonus 10) and 4 = 3000 (bonus 0).
- R3: load_i has no effect on times, rule or turn while running_o is 1, even when the clock is paused.
- R4: When running_o = 1, pause_i = 0 and tick_i = 1, the active time drops by exactly 1 on the next edge. Under rules 0, 1 and 2 the waiting time is unchanged.
- R5: With pause_i high, both times and the turn hold steady, and ticks and presses are ignored. After pause_i falls, counting resumes from the held values with no tick lost or doubled.
- R6: Only the active player's button ends a move. A press by the waiting player changes neither the turn nor either time.
- R7: Under rule 1 a move adds the bonus to the mover's time. This happens on the same edge that flips active_o.
- R8: Under rule 2 a move refunds to the mover the smaller of the time used during that move and the delay value.
- R9: Under rule 3 each counted tick takes 1 from the active player and gives 1 to the waiting player.
- R10: No time ever exceeds 108000 (180 minutes). Any addition that would pass this limit saturates at 108000.
- R11: When the active time reaches 0, that player's flag latches and running_o falls. After that, move buttons and start_i are ignored until a load.
- R12: start_i toggles running_o. A start is refused when a flag is set or the active time is 0.
- R13: Presets 5, 6 and 7 load 3000 with bonus 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 ms count strobe, one cycle per tick |
| move_a_i | input | 1 | Player A move button, debounced |
| move_b_i | input | 1 | Player B move button, debounced |
| pause_i | input | 1 | Level; freezes counting and the turn |
| start_i | input | 1 | Pulse; toggles run/stop |
| load_i | input | 1 | Pulse; loads preset and rule while stopped |
| preset_i | input | 3 | Preset index |
| rule_i | input | 2 | Rule code: 0 sudden death, 1 increment, 2 delay, 3 hourglass |
| time_a_o | output | 17 | Player A remaining time, tenths of a second |
| time_b_o | output | 17 | Player B remaining time, tenths of a second |
| active_o | output | 1 | Turn: 0 = A, 1 = B |
| running_o | output | 1 | Clock is running |
| flag_a_o | output | 1 | Player A flag fallen |
| flag_b_o | output | 1 | Player B flag fallen |

## Verification
The assertions assume that every control input is a synchronous, X-free level that changes only just after a clock edge. The step and freeze properties also assume that no load is applied while the clock runs. The stimulus raises each control for exactly one cycle and holds tick_i for a known number of cycles. It never presses both move buttons in the same cycle and never lets a press coincide with a tick. This keeps every expected count an exact sum of ticks, bonuses and refunds. Presses from the waiting player and load attempts while the clock runs are applied on purpose. After each one, the times and the turn are read back before the next action.

// File: rtl/chess_clock_pkg.sv
`timescale 1ns/1ps
package chess_clock_pkg;
  typedef enum logic [1:0] {
    RULE_SUDDEN = 2'd0,
    RULE_INCR   = 2'd1,
    RULE_DELAY  = 2'd2,
    RULE_GLASS  = 2'd3
  } rule_e;

  localparam int unsigned TENTHS_PER_MIN = 600;
  localparam int unsigned TENTHS_PER_SEC = 10;
endpackage

// File: rtl/cc_preset_table.sv
`timescale 1ns/1ps
module cc_preset_table
  import chess_clock_pkg::*;
#(
  parameter int unsigned TIME_W  = 17,
  parameter int unsigned BONUS_W = 9
) (
  input  logic [2:0]         preset_i,
  output logic [TIME_W-1:0]  start_o,
  output logic [BONUS_W-1:0] bonus_o
);
  int unsigned mins;
  int unsigned secs;

  always_comb begin
    case (preset_i)
      3'd0:    begin mins = 90; secs = 30; end
      3'd1:    begin mins = 25; secs = 5;  end
      3'd2:    begin mins = 3;  secs = 2;  end
      3'd3:    begin mins = 1;  secs = 1;  end
      default: begin mins = 5;  secs = 0;  end // 4 and reserved 5..7
    endcase
    start_o = TIME_W'(mins * TENTHS_PER_MIN);
    bonus_o = BONUS_W'(secs * TENTHS_PER_SEC);
  end
endmodule

// File: rtl/cc_move_calc.sv
`timescale 1ns/1ps
module cc_move_calc
  import chess_clock_pkg::*;
#(
  parameter int unsigned TIME_W   = 17,
  parameter int unsigned BONUS_W  = 9,
  parameter int unsigned MAX_TIME = 108000
) (
  input  logic [TIME_W-1:0]  cur_i,
  input  logic [TIME_W-1:0]  opp_i,
  input  logic [TIME_W-1:0]  snap_i,
  input  logic [BONUS_W-1:0] bonus_i,
  input  rule_e              rule_i,
  input  logic               tick_en_i,
  input  logic               move_i,
  output logic [TIME_W-1:0]  cur_o,
  output logic [TIME_W-1:0]  opp_o,
  output logic               expire_o,
  output logic               pass_o
);
  localparam logic [TIME_W:0] CAP = (TIME_W+1)'(MAX_TIME);

  function automatic logic [TIME_W-1:0] sat_add(input logic [TIME_W-1:0] a,
                                                input logic [TIME_W-1:0] b);
    logic [TIME_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > CAP) ? CAP[TIME_W-1:0] : s[TIME_W-1:0];
  endfunction

  logic [TIME_W-1:0] cur_t, opp_t, elapsed, refund, bonus_x;

  always_comb begin
    bonus_x  = TIME_W'(bonus_i);
    cur_t    = (tick_en_i && cur_i != '0) ? cur_i - 1'b1 : cur_i;
    expire_o = tick_en_i && (cur_i == TIME_W'(1));
    pass_o   = move_i && !expire_o;
    opp_t    = (tick_en_i && rule_i == RULE_GLASS) ? sat_add(opp_i, TIME_W'(1)) : opp_i;
    elapsed  = (snap_i > cur_t) ? snap_i - cur_t : '0;
    refund   = (elapsed > bonus_x) ? bonus_x : elapsed;
    cur_o    = cur_t;
    if (pass_o) begin
      case (rule_i)
        RULE_INCR:  cur_o = sat_add(cur_t, bonus_x);
        RULE_DELAY: cur_o = sat_add(cur_t, refund);
        default:    cur_o = cur_t;
      endcase
    end
    opp_o = opp_t;
  end
endmodule

// File: rtl/cc_turn_ctrl.sv
`timescale 1ns/1ps
module cc_turn_ctrl #(
  parameter int unsigned TIME_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              move_a_i,
  input  logic              move_b_i,
  input  logic              pause_i,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] act_time_i,
  input  logic              expire_i,
  input  logic              pass_i,
  output logic              run_o,
  output logic              active_o,
  output logic [1:0]        flag_o,
  output logic              tick_en_o,
  output logic              move_o,
  output logic              load_ok_o
);
  logic       run_q, active_q, adv;
  logic [1:0] flag_q;

  assign adv       = run_q & ~pause_i;
  assign tick_en_o = adv & tick_i;
  assign move_o    = adv & (active_q ? move_b_i : move_a_i);
  assign load_ok_o = load_i & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      active_q <= 1'b0;
      flag_q   <= '0;
    end else if (load_ok_o) begin
      run_q    <= 1'b0;
      active_q <= 1'b0;
      flag_q   <= '0;
    end else begin
      if (expire_i) begin
        flag_q[active_q] <= 1'b1;
        run_q            <= 1'b0;
      end else if (start_i) begin
        if (run_q)                                       run_q <= 1'b0;
        else if (flag_q == '0 && act_time_i != '0)       run_q <= 1'b1;
      end
      if (pass_i) active_q <= ~active_q;
    end
  end

  assign run_o    = run_q;
  assign active_o = active_q;
  assign flag_o   = flag_q;

  AST_FLAG_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_q)); // R11
  AST_RUN_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (flag_q == 2'b00)); // R11
  AST_PAUSE_HOLDS_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && pause_i) |=> $stable(active_q)); // R5
  AST_WAIT_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !active_q && move_b_i && !move_a_i) |=> !active_q); // R6
endmodule

// File: rtl/chess_clock.sv
`timescale 1ns/1ps
module chess_clock
  import chess_clock_pkg::*;
#(
  parameter int unsigned TIME_W   = 17,
  parameter int unsigned BONUS_W  = 9,
  parameter int unsigned MAX_TIME = 108000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              move_a_i,
  input  logic              move_b_i,
  input  logic              pause_i,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [2:0]        preset_i,
  input  logic [1:0]        rule_i,
  output logic [TIME_W-1:0] time_a_o,
  output logic [TIME_W-1:0] time_b_o,
  output logic              active_o,
  output logic              running_o,
  output logic              flag_a_o,
  output logic              flag_b_o
);
  localparam int unsigned NPLAYER = 2;

  logic [TIME_W-1:0]  time_w [NPLAYER];
  logic [TIME_W-1:0]  snap_q, preset_time, cur, opp, cur_n, opp_n;
  logic [BONUS_W-1:0] bonus_q, preset_bonus;
  rule_e              rule_q;
  logic               active, run, tick_en, move, load_ok, expire, pass;
  logic [1:0]         flags;

  cc_preset_table #(.TIME_W(TIME_W), .BONUS_W(BONUS_W)) u_preset (
    .preset_i (preset_i),
    .start_o  (preset_time),
    .bonus_o  (preset_bonus)
  );

  assign cur = time_w[active];
  assign opp = time_w[~active];

  cc_move_calc #(.TIME_W(TIME_W), .BONUS_W(BONUS_W), .MAX_TIME(MAX_TIME)) u_calc (
    .cur_i     (cur),
    .opp_i     (opp),
    .snap_i    (snap_q),
    .bonus_i   (bonus_q),
    .rule_i    (rule_q),
    .tick_en_i (tick_en),
    .move_i    (move),
    .cur_o     (cur_n),
    .opp_o     (opp_n),
    .expire_o  (expire),
    .pass_o    (pass)
  );

  cc_turn_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .move_a_i   (move_a_i),
    .move_b_i   (move_b_i),
    .pause_i    (pause_i),
    .start_i    (start_i),
    .load_i     (load_i),
    .act_time_i (cur),
    .expire_i   (expire),
    .pass_i     (pass),
    .run_o      (run),
    .active_o   (active),
    .flag_o     (flags),
    .tick_en_o  (tick_en),
    .move_o     (move),
    .load_ok_o  (load_ok)
  );

  for (genvar p = 0; p < NPLAYER; p++) begin : g_player
    logic [TIME_W-1:0] t_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    t_q <= '0;
      else if (load_ok)               t_q <= preset_time;
      else if (active == 1'(p))       t_q <= cur_n;
      else                            t_q <= opp_n;
    end
    assign time_w[p] = t_q;
  end

  // snapshot of the mover's time at turn start, used by the delay rule
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      bonus_q <= '0;
      rule_q  <= RULE_SUDDEN;
    end else if (load_ok) begin
      snap_q  <= preset_time;
      bonus_q <= preset_bonus;
      rule_q  <= rule_e'(rule_i);
    end else if (pass) begin
      snap_q  <= opp_n;
    end
  end

  assign time_a_o  = time_w[0];
  assign time_b_o  = time_w[1];
  assign active_o  = active;
  assign running_o = run;
  assign flag_a_o  = flags[0];
  assign flag_b_o  = flags[1];

  AST_TIME_CAP_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_a_o <= TIME_W'(MAX_TIME)); // R10
  AST_TIME_CAP_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_b_o <= TIME_W'(MAX_TIME)); // R10
  AST_PAUSE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && pause_i) |=> ($stable(time_a_o) && $stable(time_b_o))); // R5
  AST_TICK_STEP_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !pause_i && tick_i && !active_o && !move_a_i)
      |=> (time_a_o == $past(time_a_o) - 1'b1)); // R4
  AST_FLAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_a_o |-> (time_a_o == '0)); // R11
  AST_FLAG_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_b_o) |-> !running_o); // R11
endmodule

// File: tb/chess_clock_tb.sv
`timescale 1ns/1ps
module chess_clock_tb;
  localparam int TW = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 0, mv_a = 0, mv_b = 0, pause = 0, start = 0, load = 0;
  logic [2:0] preset = '0;
  logic [1:0] rule = '0;
  logic [TW-1:0] time_a, time_b;
  logic active, running, flag_a, flag_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chess_clock u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .move_a_i(mv_a), .move_b_i(mv_b),
    .pause_i(pause), .start_i(start), .load_i(load), .preset_i(preset), .rule_i(rule),
    .time_a_o(time_a), .time_b_o(time_b), .active_o(active), .running_o(running),
    .flag_a_o(flag_a), .flag_b_o(flag_b)
  );

  // preset -> expected start time, expected bonus (R2, R13)
  localparam int EXP_T [8] = '{54000, 15000, 1800, 600, 3000, 3000, 3000, 3000};
  localparam int EXP_B [8] = '{300, 50, 20, 10, 0, 0, 0, 0};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int p, input int r);
    preset = 3'(p); rule = 2'(r); load = 1; step(); load = 0;
  endtask
  task automatic do_start(); start = 1; step(); start = 0; endtask
  task automatic ticks(input int n); tick = 1; repeat (n) step(); tick = 0; endtask
  task automatic press_a(); mv_a = 1; step(); mv_a = 0; endtask
  task automatic press_b(); mv_b = 1; step(); mv_b = 0; endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    step();
    // R1 reset state
    chk("R1 time_a", int'(time_a), 0);
    chk("R1 time_b", int'(time_b), 0);
    chk("R1 active", int'(active), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 flags", int'({flag_a, flag_b}), 0);
    do_start();
    chk("R12 start refused at zero", int'(running), 0);

    // table walk: every preset, increment rule, one move by A
    for (int p = 0; p < 8; p++) begin
      do_load(p, 1);
      chk("R2/R13 load a", int'(time_a), EXP_T[p]);
      chk("R2/R13 load b", int'(time_b), EXP_T[p]);
      do_start();
      press_a();
      chk("R2/R13 bonus", int'(time_a), EXP_T[p] + EXP_B[p]);
      chk("R7 turn passes", int'(active), 1);
      do_start();
    end

    // sudden death, preset 3
    do_load(3, 0);
    do_start();
    chk("R12 start", int'(running), 1);
    ticks(5);
    chk("R4 active dec", int'(time_a), 595);
    chk("R4 waiting held", int'(time_b), 600);
    press_b();
    chk("R6 waiting press turn", int'(active), 0);
    chk("R6 waiting press time", int'(time_a), 595);
    press_a();
    chk("R6 active press", int'(active), 1);
    chk("R4 no bonus rule 0", int'(time_a), 595);
    ticks(3);
    chk("R4 b dec", int'(time_b), 597);
    pause = 1;
    ticks(4);
    chk("R5 paused b", int'(time_b), 597);
    press_b();
    chk("R5 paused turn", int'(active), 1);
    chk("R5 paused a", int'(time_a), 595);
    pause = 0;
    ticks(1);
    chk("R5 resume one tick", int'(time_b), 596);
    do_load(2, 0);
    chk("R3 load ignored a", int'(time_a), 595);
    chk("R3 load ignored b", int'(time_b), 596);
    do_start();
    chk("R12 stop", int'(running), 0);
    do_start();
    chk("R12 restart", int'(running), 1);
    do_start();

    // increment rule
    do_load(3, 1);
    do_start();
    ticks(7);
    press_a();
    chk("R7 incr a", int'(time_a), 603);
    ticks(2);
    press_b();
    chk("R7 incr b", int'(time_b), 608);
    do_start();

    // saturation
    do_load(0, 1);
    do_start();
    for (int i = 0; i < 200; i++) begin press_a(); press_b(); end
    chk("R10 sat a", int'(time_a), 108000);
    chk("R10 sat b", int'(time_b), 108000);
    do_start();

    // delay rule
    do_load(2, 2);
    do_start();
    ticks(12);
    press_a();
    chk("R8 refund full", int'(time_a), 1800);
    ticks(35);
    press_b();
    chk("R8 refund capped", int'(time_b), 1785);
    do_start();

    // hourglass
    do_load(3, 3);
    do_start();
    ticks(10);
    chk("R9 glass a", int'(time_a), 590);
    chk("R9 glass b", int'(time_b), 610);
    press_a();
    ticks(4);
    chk("R9 glass b2", int'(time_b), 606);
    chk("R9 glass a2", int'(time_a), 594);
    do_start();

    // flag fall
    do_load(3, 0);
    do_start();
    ticks(600);
    chk("R11 a zero", int'(time_a), 0);
    chk("R11 flag a", int'(flag_a), 1);
    chk("R11 flag b", int'(flag_b), 0);
    chk("R11 stopped", int'(running), 0);
    press_a();
    chk("R11 press ignored", int'(active), 0);
    do_start();
    chk("R11 start refused", int'(running), 0);
    do_load(3, 0);
    chk("R2 flag cleared", int'(flag_a), 0);
    chk("R2 reload", int'(time_a), 600);

    done = 1;
    summary();
    $finish;
  end
endmodule